// File: doc/BRIEF.md
# Completion-Driven Clock Frequency Calibrator

This controller closes the loop between a timing detector on an adder pipeline's critical path and the clock generator that paces that pipeline. It holds a frequency code that an external converter and oscillator turn into a clock rate. A larger code means a faster clock. The detector reports, for each evaluation, whether the monitored path arrived late, or arrived with spare margin. A separate flag says whether the operand on that path was the worst-case vector. Only worst-case observations are trusted. A late arrival slows the clock by one step, a comfortable arrival speeds it up by one step, and anything in between holds the code.

After reset the controller runs a startup calibration. It asks the datapath to inject the worst-case vector, and it keeps stepping the code until a programmable number of consecutive accepted observations say "hold". It then raises a calibrated flag and stops forcing the vector. From then on it keeps adjusting the code in place, whenever the worst-case vector turns up in real traffic. Each code change starts a settle window. During that window the controller blocks datapath evaluation and ignores the detector, so that no result is taken while the clock is moving.

Top module: `clkcal_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, before any accepted observation: `freq_code` equals INIT_CODE (default 128), `force_wc` = 1, `calibrated` = 0 and `eval_inhibit` = 0.
- R2: An observation is accepted only in a cycle where `wc_hit` = 1 and `eval_inhibit` = 0. In every other cycle the code is left unchanged, whatever `chk_late` and `chk_fast` carry.
- R3: An accepted observation with `chk_late` = 1 lowers `freq_code` by exactly 1 at the next clock edge. `chk_late` takes priority over `chk_fast` when both are 1.
- R4: An accepted observation with `chk_late` = 0 and `chk_fast` = 1 raises `freq_code` by exactly 1 at the next clock edge.
- R5: An accepted observation with both `chk_late` = 0 and `chk_fast` = 0 is a hold result, and it leaves the code unchanged.
- R6: The code saturates. A late result at code 0 keeps it at 0, and a fast result at the all-ones code (255) keeps it at 255. Neither case counts as a change.
- R7: Every code change sets `eval_inhibit` = 1 for exactly SETTLE_CYC cycles (default 4), starting with the cycle in which the new code appears. A saturated result does not raise it.
- R8: `force_wc` stays 1 until LOCK_HOLDS (default 3) consecutive accepted hold results have been seen. Any accepted late or fast result restarts that count. From the cycle after the last of those holds, `calibrated` = 1 and `force_wc` = 0.
- R9: Once `calibrated` is 1, it stays 1 until reset. Accepted observations keep adjusting the code under R3 to R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wc_hit | input | 1 | The operand on the monitored path is the worst-case vector |
| chk_late | input | 1 | The monitored path missed its completion window |
| chk_fast | input | 1 | The monitored path completed with margin to spare |
| freq_code | output | CODE_W (8) | Frequency code sent to the converter and oscillator |
| force_wc | output | 1 | Asks the datapath to inject the worst-case vector |
| eval_inhibit | output | 1 | Blocks datapath evaluation while the clock settles |
| calibrated | output | 1 | Startup calibration has completed |

## Verification
The properties assume that the detector flags are meaningful only alongside `wc_hit`. They also assume that a result offered during the settle window must be discarded. Under those assumptions they can require the code to stay put whenever either condition fails, and to move by exactly one step otherwise. The stimulus deliberately breaks the detector's normal contract: it drives late and fast flags with `wc_hit` low, during inhibit, and both flags at once. The properties still hold in those cases, because each of them is conditioned on acceptance. The sweeps drive the code to both end stops so that saturation is reached, rather than assumed away.

// File: rtl/clkcal_pkg.sv
package clkcal_pkg;

    // Action decoded from one timing-check result
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_UP   = 2'd1,
        ACT_DOWN = 2'd2
    } act_e;

    // Controller phase: startup calibration or in-situ tracking
    typedef enum logic {
        MODE_CAL = 1'b0,
        MODE_RUN = 1'b1
    } mode_e;

endpackage

// File: rtl/clkcal_decide.sv
module clkcal_decide
    import clkcal_pkg::*;
(
    input  logic late_i,
    input  logic fast_i,
    output act_e act_o
);

    // A late arrival outranks a margin report: slowing down is the safe choice
    always_comb begin
        act_o = ACT_HOLD;
        if (late_i) begin
            act_o = ACT_DOWN;
        end else if (fast_i) begin
            act_o = ACT_UP;
        end
    end

endmodule

// File: rtl/clkcal_code.sv
module clkcal_code
    import clkcal_pkg::*;
#(
    parameter int CODE_W    = 8,
    parameter int INIT_CODE = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              obs_i,
    input  act_e              act_i,
    output logic [CODE_W-1:0] code_o,
    output logic              moved_o
);

    localparam logic [CODE_W-1:0] CODE_MAX  = '1;
    localparam logic [CODE_W-1:0] CODE_MIN  = '0;
    localparam logic [CODE_W-1:0] CODE_RST  = CODE_W'(INIT_CODE);

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } code_st_t;

    code_st_t st_d, st_q;
    logic     moved_d;

    always_comb begin
        st_d    = st_q;
        moved_d = 1'b0;
        if (obs_i) begin
            case (act_i)
                ACT_UP: begin
                    if (st_q.code != CODE_MAX) begin
                        st_d.code = st_q.code + 1'b1;
                        moved_d   = 1'b1;
                    end
                end
                ACT_DOWN: begin
                    if (st_q.code != CODE_MIN) begin
                        st_d.code = st_q.code - 1'b1;
                        moved_d   = 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.code <= CODE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o  = st_q.code;
    assign moved_o = moved_d;

endmodule

// File: rtl/clkcal_seq.sv
module clkcal_seq
    import clkcal_pkg::*;
#(
    parameter int SETTLE_CYC = 4,
    parameter int LOCK_HOLDS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic obs_i,
    input  act_e act_i,
    input  logic moved_i,
    output logic inhibit_o,
    output logic force_o,
    output logic cal_o
);

    localparam int SETTLE_W = $clog2(SETTLE_CYC + 1);
    localparam int STREAK_W = $clog2(LOCK_HOLDS + 1);
    localparam logic [SETTLE_W-1:0] SETTLE_LOAD = SETTLE_W'(SETTLE_CYC);
    localparam logic [STREAK_W-1:0] STREAK_TOP  = STREAK_W'(LOCK_HOLDS);
    localparam logic [STREAK_W-1:0] STREAK_LAST = STREAK_W'(LOCK_HOLDS - 1);

    typedef struct packed {
        mode_e               mode;
        logic [STREAK_W-1:0] streak;
        logic [SETTLE_W-1:0] settle;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        // Settle window: count down, reload on every code change
        if (st_q.settle != '0) begin
            st_d.settle = st_q.settle - 1'b1;
        end
        if (moved_i) begin
            st_d.settle = SETTLE_LOAD;
        end

        // Consecutive-hold tracking for the startup lock
        if (obs_i) begin
            if (act_i == ACT_HOLD) begin
                if (st_q.streak != STREAK_TOP) begin
                    st_d.streak = st_q.streak + 1'b1;
                end
                if (st_q.mode == MODE_CAL && st_q.streak == STREAK_LAST) begin
                    st_d.mode = MODE_RUN;
                end
            end else begin
                st_d.streak = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode   <= MODE_CAL;
            st_q.streak <= '0;
            st_q.settle <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign inhibit_o = (st_q.settle != '0);
    assign force_o   = (st_q.mode == MODE_CAL);
    assign cal_o     = (st_q.mode == MODE_RUN);

endmodule

// File: rtl/clkcal_ctrl.sv
module clkcal_ctrl
    import clkcal_pkg::*;
#(
    parameter int CODE_W     = 8,
    parameter int INIT_CODE  = 128,
    parameter int SETTLE_CYC = 4,
    parameter int LOCK_HOLDS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wc_hit,
    input  logic              chk_late,
    input  logic              chk_fast,
    output logic [CODE_W-1:0] freq_code,
    output logic              force_wc,
    output logic              eval_inhibit,
    output logic              calibrated
);

    act_e act;
    logic obs;
    logic moved;

    // A result counts only for the worst-case vector and outside a settle window
    assign obs = wc_hit & ~eval_inhibit;

    clkcal_decide u_decide (
        .late_i (chk_late),
        .fast_i (chk_fast),
        .act_o  (act)
    );

    clkcal_code #(
        .CODE_W    (CODE_W),
        .INIT_CODE (INIT_CODE)
    ) u_code (
        .clk     (clk),
        .rst_n   (rst_n),
        .obs_i   (obs),
        .act_i   (act),
        .code_o  (freq_code),
        .moved_o (moved)
    );

    clkcal_seq #(
        .SETTLE_CYC (SETTLE_CYC),
        .LOCK_HOLDS (LOCK_HOLDS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .obs_i     (obs),
        .act_i     (act),
        .moved_i   (moved),
        .inhibit_o (eval_inhibit),
        .force_o   (force_wc),
        .cal_o     (calibrated)
    );

endmodule

// File: rtl/clkcal_chk.sv
module clkcal_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wc_hit,
    input logic              chk_late,
    input logic              chk_fast,
    input logic [CODE_W-1:0] freq_code,
    input logic              force_wc,
    input logic              eval_inhibit,
    input logic              calibrated
);

    localparam logic [CODE_W-1:0] ONE = CODE_W'(1);
    localparam logic [CODE_W-1:0] TOP = '1;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_code != $past(freq_code)) |->
            ((freq_code == $past(freq_code) + ONE) || (freq_code == $past(freq_code) - ONE))); // R3

    AST_IGNORE_NO_WC: assert property (@(posedge clk) disable iff (!rst_n)
        !wc_hit |=> $stable(freq_code)); // R2

    AST_IGNORE_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        eval_inhibit |=> $stable(freq_code)); // R2

    AST_CHANGE_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_code != $past(freq_code)) |-> eval_inhibit); // R7

    AST_SLOW_ON_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wc_hit && !eval_inhibit && chk_late && freq_code != '0) |=>
            (freq_code == $past(freq_code) - ONE)); // R3

    AST_FAST_ON_MARGIN: assert property (@(posedge clk) disable iff (!rst_n)
        (wc_hit && !eval_inhibit && !chk_late && chk_fast && freq_code != TOP) |=>
            (freq_code == $past(freq_code) + ONE)); // R4

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_late && !chk_fast) |=> $stable(freq_code)); // R5

    AST_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (wc_hit && !eval_inhibit && chk_late && freq_code == '0) |=> (freq_code == '0)); // R6

    AST_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        (wc_hit && !eval_inhibit && !chk_late && chk_fast && freq_code == TOP) |=> (freq_code == TOP)); // R6

    AST_LOCK_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(calibrated) |-> $past(wc_hit && !chk_late && !chk_fast && !eval_inhibit)); // R8

    AST_CAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        calibrated |=> (calibrated && !force_wc)); // R9

endmodule

bind clkcal_ctrl clkcal_chk #(.CODE_W(CODE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wc_hit       (wc_hit),
    .chk_late     (chk_late),
    .chk_fast     (chk_fast),
    .freq_code    (freq_code),
    .force_wc     (force_wc),
    .eval_inhibit (eval_inhibit),
    .calibrated   (calibrated)
);

// File: tb/sim_clkcal_ctrl.sv
`timescale 1ns/1ps
module sim_clkcal_ctrl;

    localparam int CW     = 8;
    localparam int INIT   = 128;
    localparam int SETTLE = 4;
    localparam int LOCK   = 3;
    localparam int CMAX   = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wc_hit = 1'b0;
    logic          chk_late = 1'b0;
    logic          chk_fast = 1'b0;
    logic [CW-1:0] freq_code;
    logic          force_wc;
    logic          eval_inhibit;
    logic          calibrated;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state, derived from the requirements
    int m_code;
    int m_settle;
    int m_streak;
    bit m_cal;

    always #4 clk = ~clk;

    clkcal_ctrl #(
        .CODE_W     (CW),
        .INIT_CODE  (INIT),
        .SETTLE_CYC (SETTLE),
        .LOCK_HOLDS (LOCK)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .wc_hit       (wc_hit),
        .chk_late     (chk_late),
        .chk_fast     (chk_fast),
        .freq_code    (freq_code),
        .force_wc     (force_wc),
        .eval_inhibit (eval_inhibit),
        .calibrated   (calibrated)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "freq_code", int'(freq_code), m_code);
        chk(tag, "eval_inhibit", int'(eval_inhibit), int'(m_settle != 0));
        chk(tag, "force_wc", int'(force_wc), int'(!m_cal));
        chk(tag, "calibrated", int'(calibrated), int'(m_cal));
    endtask

    // One cycle: drive at the falling edge, update the model at the rising edge,
    // compare at the next falling edge
    task automatic cyc(input bit w, input bit l, input bit f, input string tag);
        bit acc;
        wc_hit   = w;
        chk_late = l;
        chk_fast = f;
        @(posedge clk);
        acc = w && (m_settle == 0);
        if (m_settle != 0) m_settle--;
        if (acc) begin
            if (l) begin
                if (m_code > 0) begin
                    m_code--;
                    m_settle = SETTLE;
                end
                m_streak = 0;
            end else if (f) begin
                if (m_code < CMAX) begin
                    m_code++;
                    m_settle = SETTLE;
                end
                m_streak = 0;
            end else begin
                if (m_streak < LOCK) m_streak++;
                if (m_streak == LOCK) m_cal = 1;
            end
        end
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        m_code = INIT; m_settle = 0; m_streak = 0; m_cal = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_all("R1");

        // R2: detector flags without the worst-case vector are ignored
        cyc(1'b0, 1'b1, 1'b0, "R2");
        cyc(1'b0, 1'b0, 1'b1, "R2");
        cyc(1'b0, 1'b1, 1'b1, "R2");

        // R4: speed up, then R7 settle window with R2 results ignored inside it
        cyc(1'b1, 1'b0, 1'b1, "R4");
        cyc(1'b1, 1'b1, 1'b0, "R7");
        cyc(1'b1, 1'b0, 1'b0, "R7");
        cyc(1'b1, 1'b0, 1'b1, "R2");
        cyc(1'b1, 1'b1, 1'b1, "R7");
        cyc(1'b1, 1'b1, 1'b0, "R3");
        idle(SETTLE, "R7");

        // R8: two holds, then a margin result restarts the streak
        cyc(1'b1, 1'b0, 1'b0, "R5");
        cyc(1'b1, 1'b0, 1'b0, "R8");
        cyc(1'b1, 1'b0, 1'b1, "R8");
        idle(SETTLE, "R7");
        cyc(1'b1, 1'b0, 1'b0, "R8");
        cyc(1'b0, 1'b0, 1'b0, "R8");
        cyc(1'b1, 1'b0, 1'b0, "R8");
        cyc(1'b1, 1'b0, 1'b0, "R8");
        chk("R8", "calibrated after lock", int'(calibrated), 1);

        // R3: both flags at once slows the clock
        cyc(1'b1, 1'b1, 1'b1, "R3");
        idle(SETTLE, "R7");

        // R4/R6: sweep to the top end stop
        while (m_code < CMAX) begin
            cyc(1'b1, 1'b0, 1'b1, "R4");
            idle(SETTLE, "R7");
        end
        cyc(1'b1, 1'b0, 1'b1, "R6");
        cyc(1'b1, 1'b0, 1'b1, "R6");
        chk("R6", "ceiling no inhibit", int'(eval_inhibit), 0);

        // R3/R6: sweep to the bottom end stop
        while (m_code > 0) begin
            cyc(1'b1, 1'b1, 1'b0, "R3");
            idle(SETTLE, "R7");
        end
        cyc(1'b1, 1'b1, 1'b0, "R6");
        cyc(1'b1, 1'b1, 1'b1, "R6");
        chk("R6", "floor code", int'(freq_code), 0);

        // R9: pseudo-random in-situ traffic after calibration
        begin
            logic [15:0] lfsr = 16'hACE1;
            for (int i = 0; i < 3000; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                cyc(lfsr[0] & lfsr[3], lfsr[1] & lfsr[5], lfsr[2], "R9");
            end
        end
        chk("R9", "calibrated sticky", int'(calibrated), 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule